// File: doc/BRIEF.md
# Beam Position Frame Checker

This block sits after a receive-frame parser in a beam position monitor link. Each frame arrives already split into fields: a CRC-good flag, a 16-bit sequence number, a 16-bit monitor ID, 32-bit X and Y positions and a 40-bit timestamp. Frames that fail their CRC are dropped and counted. Frames that pass are counted, checked for sequence continuity and per-sequence frame count, and then sent out as one 128-bit stream beat.

Frames that share a sequence number form one sequence. When a good frame carries a different sequence number, the sequence before it is complete. Its frame count is then published and compared with the count of the sequence before that one. Two 32-bit totals, one for good frames and one for bad frames, run freely. Each total has a rate value that holds the number of its events in the last closed window of `RATE_WINDOW` cycles. The default window is one second at a 100 MHz clock. A synchronous soft reset clears every count, rate and status flag and restarts sequence tracking and the rate window.

The output stream has valid but no ready. Every accepted frame produces exactly one beat, with last set, one cycle later. The block never stalls and has no buffer, so the downstream side must take every beat in the cycle it appears. The input side is valid-only for the same reason: a frame is taken in every cycle where `frm_valid` is high.

Top module: `bpm_frame_checker`

## Requirements
- R1: A frame with `frm_valid`=1 and `frm_crc_ok`=0 produces no stream beat, drives `frame_err` high for exactly the next cycle, and raises `invalid_cnt` by one.
- R2: A frame with `frm_valid`=1 and `frm_crc_ok`=1 drives `m_tvalid` high with `m_tlast`=1 for exactly the next cycle and raises `valid_cnt` by one. There is no ready input and the output never waits.
- R3: `m_tdata` packs the fields from LSB to MSB as follows: X in bits [31:0], Y in bits [63:32], ID in bits [79:64], timestamp in bits [119:80] and sequence bits [7:0] in bits [127:120].
- R4: When a good frame carries a sequence number that differs from the current one, `seq_frame_cnt` shows, from the next cycle on, the number of good frames that carried the previous sequence number. Bad-CRC frames do not take part in sequence tracking.
- R5: On such a change, if the new number is not the previous one plus one modulo 2^16, `seq_disc` pulses for one cycle and `seq_disc_sticky` is set. A step from 0xFFFF to 0x0000 is continuous.
- R6: `seq_cnt_mismatch` is set, and stays set, when a completed sequence's frame count differs from the count of the sequence completed before it.
- R7: The first sequence seen after reset or soft reset never raises `seq_disc` and is never compared for a count mismatch.
- R8: `valid_rate` and `invalid_rate` each hold the number of matching frames taken during the most recently closed window of `RATE_WINDOW` cycles. A window closes every `RATE_WINDOW` cycles, counted from reset or soft reset, and the rate values are 0 until the first window closes.
- R9: `soft_rst`=1 clears `valid_cnt`, `invalid_cnt`, both rates, `seq_frame_cnt`, both sticky flags and sequence history on the next edge.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of counters, rates and flags |
| frm_valid | input | 1 | A parsed frame is present this cycle |
| frm_crc_ok | input | 1 | CRC of the present frame was good |
| frm_seq | input | 16 | Sequence number |
| frm_id | input | 16 | Source monitor ID |
| frm_x | input | 32 | X position |
| frm_y | input | 32 | Y position |
| frm_ts | input | 40 | Timestamp |
| m_tvalid | output | 1 | Stream beat valid (no ready exists) |
| m_tdata | output | 128 | Packed position word |
| m_tlast | output | 1 | Set on every beat |
| frame_err | output | 1 | One-cycle pulse per bad-CRC frame |
| seq_disc | output | 1 | One-cycle pulse on a sequence number jump |
| seq_frame_cnt | output | 16 | Frame count of the last completed sequence |
| seq_disc_sticky | output | 1 | Sticky jump flag |
| seq_cnt_mismatch | output | 1 | Sticky frame-count mismatch flag |
| valid_cnt | output | 32 | Good-frame total |
| invalid_cnt | output | 32 | Bad-frame total |
| valid_rate | output | 32 | Good frames in the last closed window |
| invalid_rate | output | 32 | Bad frames in the last closed window |

## Verification
Suppose the sequence tracker holds the wrong current number or count. This shows at the ports on the next sequence change: a false `seq_disc` pulse, a wrong `seq_frame_cnt`, or a mismatch flag that is stuck or missing, each visible one cycle after the first good frame of the new sequence. A wrong field placement or a dropped beat shows in `m_tdata` and `m_tvalid` one cycle after the frame is presented. A fault in the rate logic stays hidden until the first window closes, so the bench shortens the window and reads both rates just after it closes.

// File: rtl/bpmfc_pkg.sv
package bpmfc_pkg;
  localparam int POS_W   = 32;
  localparam int ID_W    = 16;
  localparam int TS_W    = 40;
  localparam int SEQ_W   = 16;
  localparam int SEQLO_W = 8;

  // first member lands in the most significant bits
  typedef struct packed {
    logic [SEQLO_W-1:0] seq_lo;
    logic [TS_W-1:0]    ts;
    logic [ID_W-1:0]    id;
    logic [POS_W-1:0]   y;
    logic [POS_W-1:0]   x;
  } pos_word_t;

  localparam int WORD_W = $bits(pos_word_t);
endpackage

// File: rtl/bpmfc_window_timer.sv
module bpmfc_window_timer #(
  parameter int WINDOW = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int W_W = $clog2(WINDOW + 1);
  localparam logic [W_W-1:0] LAST = W_W'(WINDOW - 1);

  logic [W_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R8
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/bpmfc_event_stats.sv
module bpmfc_event_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             ev,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] rate
);
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] inc;

  assign inc = CNT_W'(ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      rate  <= '0;
      acc_q <= '0;
    end else if (clr) begin
      total <= '0;
      rate  <= '0;
      acc_q <= '0;
    end else begin
      total <= total + inc;
      if (tick) begin
        rate  <= acc_q + inc;
        acc_q <= '0;
      end else begin
        acc_q <= acc_q + inc;
      end
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    1'b1 |=> (total == $past(total) || total == $past(total) + 1'b1));

  // R8
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !tick |=> $stable(rate));
endmodule

// File: rtl/bpmfc_seq_tracker.sv
module bpmfc_seq_tracker #(
  parameter int SEQ_W  = 16,
  parameter int FCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev,
  input  logic [SEQ_W-1:0]  seq,
  output logic              disc_pulse,
  output logic [FCNT_W-1:0] done_cnt,
  output logic              disc_sticky,
  output logic              mis_sticky
);
  logic              have_seq_q;
  logic              have_done_q;
  logic [SEQ_W-1:0]  cur_seq_q;
  logic [FCNT_W-1:0] cur_cnt_q;
  logic              changed;
  logic              jumped;

  assign changed = ev && have_seq_q && (seq != cur_seq_q);
  assign jumped  = changed && (seq != cur_seq_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_seq_q  <= 1'b0;
      have_done_q <= 1'b0;
      cur_seq_q   <= '0;
      cur_cnt_q   <= '0;
      done_cnt    <= '0;
      disc_pulse  <= 1'b0;
      disc_sticky <= 1'b0;
      mis_sticky  <= 1'b0;
    end else if (clr) begin
      have_seq_q  <= 1'b0;
      have_done_q <= 1'b0;
      cur_seq_q   <= '0;
      cur_cnt_q   <= '0;
      done_cnt    <= '0;
      disc_pulse  <= 1'b0;
      disc_sticky <= 1'b0;
      mis_sticky  <= 1'b0;
    end else begin
      disc_pulse <= jumped;
      if (jumped) disc_sticky <= 1'b1;
      if (ev) begin
        if (!have_seq_q || changed) begin
          have_seq_q <= 1'b1;
          cur_seq_q  <= seq;
          cur_cnt_q  <= FCNT_W'(1);
        end else begin
          cur_cnt_q  <= cur_cnt_q + 1'b1;
        end
        if (changed) begin
          done_cnt    <= cur_cnt_q;
          have_done_q <= 1'b1;
          if (have_done_q && (cur_cnt_q != done_cnt)) mis_sticky <= 1'b1;
        end
      end
    end
  end

  // R5
  disc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_pulse |-> disc_sticky);

  // R7
  first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (ev && !have_seq_q) |=> !disc_pulse);

  // R6
  mis_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    mis_sticky |=> mis_sticky);
endmodule

// File: rtl/bpm_frame_checker.sv
module bpm_frame_checker
  import bpmfc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int FCNT_W      = 16,
  parameter int RATE_WINDOW = 100_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               frm_valid,
  input  logic               frm_crc_ok,
  input  logic [SEQ_W-1:0]   frm_seq,
  input  logic [ID_W-1:0]    frm_id,
  input  logic [POS_W-1:0]   frm_x,
  input  logic [POS_W-1:0]   frm_y,
  input  logic [TS_W-1:0]    frm_ts,
  output logic               m_tvalid,
  output logic [WORD_W-1:0]  m_tdata,
  output logic               m_tlast,
  output logic               frame_err,
  output logic               seq_disc,
  output logic [FCNT_W-1:0]  seq_frame_cnt,
  output logic               seq_disc_sticky,
  output logic               seq_cnt_mismatch,
  output logic [CNT_W-1:0]   valid_cnt,
  output logic [CNT_W-1:0]   invalid_cnt,
  output logic [CNT_W-1:0]   valid_rate,
  output logic [CNT_W-1:0]   invalid_rate
);
  localparam int NSTAT = 2;

  logic good_ev;
  logic bad_ev;
  logic tick;
  logic [NSTAT-1:0]       stat_ev;
  logic [CNT_W-1:0]       stat_total [NSTAT];
  logic [CNT_W-1:0]       stat_rate  [NSTAT];
  pos_word_t              word_d;

  assign good_ev = frm_valid &&  frm_crc_ok;
  assign bad_ev  = frm_valid && !frm_crc_ok;
  assign stat_ev = {bad_ev, good_ev};

  assign word_d = '{seq_lo: frm_seq[SEQLO_W-1:0], ts: frm_ts, id: frm_id,
                    y: frm_y, x: frm_x};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tvalid  <= 1'b0;
      m_tdata   <= '0;
      frame_err <= 1'b0;
    end else begin
      m_tvalid  <= good_ev;
      frame_err <= bad_ev;
      if (good_ev) m_tdata <= word_d;
    end
  end

  assign m_tlast = m_tvalid;

  bpmfc_window_timer #(.WINDOW(RATE_WINDOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick)
  );

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    bpmfc_event_stats #(.CNT_W(CNT_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick),
      .ev(stat_ev[g]), .total(stat_total[g]), .rate(stat_rate[g])
    );
  end

  assign valid_cnt    = stat_total[0];
  assign invalid_cnt  = stat_total[1];
  assign valid_rate   = stat_rate[0];
  assign invalid_rate = stat_rate[1];

  bpmfc_seq_tracker #(.SEQ_W(SEQ_W), .FCNT_W(FCNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .ev(good_ev), .seq(frm_seq),
    .disc_pulse(seq_disc), .done_cnt(seq_frame_cnt),
    .disc_sticky(seq_disc_sticky), .mis_sticky(seq_cnt_mismatch)
  );

  // R1
  drop_bad_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> (!m_tvalid && frame_err));

  // R2
  fwd_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_ev |=> (m_tvalid && !frame_err));

  // R2
  one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !m_tvalid);
endmodule

// File: tb/bpm_frame_checker_tb.sv
module bpm_frame_checker_tb;
  localparam int WIN = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soft_rst = 1'b0;
  logic         frm_valid = 1'b0;
  logic         frm_crc_ok = 1'b0;
  logic [15:0]  frm_seq = '0;
  logic [15:0]  frm_id = '0;
  logic [31:0]  frm_x = '0;
  logic [31:0]  frm_y = '0;
  logic [39:0]  frm_ts = '0;
  logic         m_tvalid, m_tlast, frame_err, seq_disc;
  logic [127:0] m_tdata;
  logic [15:0]  seq_frame_cnt;
  logic         seq_disc_sticky, seq_cnt_mismatch;
  logic [31:0]  valid_cnt, invalid_cnt, valid_rate, invalid_rate;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bpm_frame_checker #(.RATE_WINDOW(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .frm_valid(frm_valid), .frm_crc_ok(frm_crc_ok), .frm_seq(frm_seq),
    .frm_id(frm_id), .frm_x(frm_x), .frm_y(frm_y), .frm_ts(frm_ts),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .frame_err(frame_err), .seq_disc(seq_disc), .seq_frame_cnt(seq_frame_cnt),
    .seq_disc_sticky(seq_disc_sticky), .seq_cnt_mismatch(seq_cnt_mismatch),
    .valid_cnt(valid_cnt), .invalid_cnt(invalid_cnt),
    .valid_rate(valid_rate), .invalid_rate(invalid_rate)
  );

  typedef struct packed {
    logic        crc;
    logic [15:0] seq;
    logic        e_tvalid;
    logic        e_err;
    logic        e_disc;
    logic [15:0] e_cnt;
    logic        e_mis;
    logic        e_sdisc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'd5,  1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0},
    '{1'b1, 16'd5,  1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0},
    '{1'b1, 16'd5,  1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0},
    '{1'b1, 16'd6,  1'b1, 1'b0, 1'b0, 16'd3, 1'b0, 1'b0},
    '{1'b1, 16'd6,  1'b1, 1'b0, 1'b0, 16'd3, 1'b0, 1'b0},
    '{1'b1, 16'd6,  1'b1, 1'b0, 1'b0, 16'd3, 1'b0, 1'b0},
    '{1'b1, 16'd7,  1'b1, 1'b0, 1'b0, 16'd3, 1'b0, 1'b0},
    '{1'b1, 16'd7,  1'b1, 1'b0, 1'b0, 16'd3, 1'b0, 1'b0},
    '{1'b0, 16'd99, 1'b0, 1'b1, 1'b0, 16'd3, 1'b0, 1'b0},
    '{1'b1, 16'd9,  1'b1, 1'b0, 1'b1, 16'd2, 1'b1, 1'b1},
    '{1'b1, 16'd9,  1'b1, 1'b0, 1'b0, 16'd2, 1'b1, 1'b1},
    '{1'b0, 16'd10, 1'b0, 1'b1, 1'b0, 16'd2, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic send(input logic crc, input logic [15:0] seq,
                      input logic [15:0] id, input logic [31:0] x,
                      input logic [31:0] y, input logic [39:0] ts);
    frm_valid = 1'b1; frm_crc_ok = crc; frm_seq = seq;
    frm_id = id; frm_x = x; frm_y = y; frm_ts = ts;
    @(posedge clk); @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic pulse_soft();
    soft_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    soft_rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ev_ok = 0;
    int ev_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10", "tvalid", m_tvalid, 0);
    chk("R10", "err", frame_err, 0);
    chk("R10", "disc", seq_disc, 0);
    chk("R10", "flags", {seq_disc_sticky, seq_cnt_mismatch}, 0);
    chk("R10", "counts", {valid_cnt, invalid_cnt, seq_frame_cnt}, 0);
    chk("R10", "rates", {valid_rate, invalid_rate}, 0);

    // vector table: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].crc, VEC[i].seq, 16'(i), 32'(i * 3), 32'(i * 7), 40'(i));
      if (VEC[i].crc) ev_ok++; else ev_bad++;
      chk("R2", "tvalid", m_tvalid, VEC[i].e_tvalid);
      chk("R1", "frame_err", frame_err, VEC[i].e_err);
      chk("R5", "seq_disc", seq_disc, VEC[i].e_disc);
      chk("R4", "seq_frame_cnt", seq_frame_cnt, VEC[i].e_cnt);
      chk("R6", "mismatch", seq_cnt_mismatch, VEC[i].e_mis);
      chk("R5", "disc_sticky", seq_disc_sticky, VEC[i].e_sdisc);
      chk("R2", "valid_cnt", valid_cnt, ev_ok);
      chk("R1", "invalid_cnt", invalid_cnt, ev_bad);
      if (i < 3) chk("R7", "first seq quiet", {seq_disc, seq_cnt_mismatch}, 0);
    end
    // R1 R2 single-cycle pulses
    @(negedge clk);
    chk("R2", "tvalid drops", m_tvalid, 0);
    chk("R1", "err drops", frame_err, 0);
    chk("R6", "mismatch kept", seq_cnt_mismatch, 1);

    // R3 packing and R2 last flag
    send(1'b1, 16'h12EF, 16'hABCD, 32'h11223344, 32'h55667788, 40'h0102030405);
    chk("R3", "tdata", m_tdata,
        {8'hEF, 40'h0102030405, 16'hABCD, 32'h55667788, 32'h11223344});
    chk("R2", "tlast", m_tlast, 1);

    // R9 soft reset clears
    pulse_soft();
    chk("R9", "counters", {valid_cnt, invalid_cnt}, 0);
    chk("R9", "flags", {seq_disc_sticky, seq_cnt_mismatch}, 0);
    chk("R9", "seq_frame_cnt", seq_frame_cnt, 0);

    // R8 rate window: frames at edges 1..8 after the soft-reset edge
    for (int k = 0; k < 8; k++) begin
      send(k < 5, 16'd40, 16'd1, 32'd0, 32'd0, 40'd0);
    end
    chk("R8", "rate before close", {valid_rate, invalid_rate}, 0);
    repeat (9) @(negedge clk);
    chk("R8", "valid_rate", valid_rate, 5);
    chk("R8", "invalid_rate", invalid_rate, 3);
    chk("R7", "no disc after soft reset", seq_disc_sticky, 0);
    repeat (WIN) @(negedge clk);
    chk("R8", "idle window rate", valid_rate, 0);
    chk("R8", "totals kept", {valid_cnt, invalid_cnt}, {32'd5, 32'd3});

    // R9 rates cleared
    pulse_soft();
    chk("R9", "rates", {valid_rate, invalid_rate}, 0);

    // R5 wrap is continuous, then a jump
    send(1'b1, 16'hFFFF, 16'd2, 32'd0, 32'd0, 40'd0);
    send(1'b1, 16'h0000, 16'd2, 32'd0, 32'd0, 40'd0);
    chk("R5", "wrap no disc", {seq_disc, seq_disc_sticky}, 0);
    chk("R4", "wrap count", seq_frame_cnt, 1);
    send(1'b1, 16'h0002, 16'd2, 32'd0, 32'd0, 40'd0);
    chk("R5", "jump disc", {seq_disc, seq_disc_sticky}, 2'b11);
    chk("R6", "equal counts no mismatch", seq_cnt_mismatch, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule